// File: doc/BRIEF.md
# Command-Addressed SPI Slave

This block is a serial-peripheral slave for use inside an FPGA. A master frames every exchange with slave select held low. It sends an 8-bit command, most significant bit first, and then exactly `DW` data bits. Two bits of that command choose, each on its own, where the incoming MOSI data goes and what is shifted back on MISO. The data can go to the receive register or to the status register. The read-back can come from the transmit register or from the status register. The clock polarity (`CPOL`) and phase (`CPHA`) are parameters.

All logic runs on the single fabric clock `clk`. `sclk`, `ss_n` and `mosi` are taken as already synchronous to `clk`, and `clk` must run at least four times faster than `sclk`. The block finds SCLK edges by comparing each sample of `sclk` with the one before it. The user side has the following controls:

- A transmit-load handshake. `tx_ready` is the inverse of `busy`. A word is taken only in a cycle where `tx_valid` and `tx_ready` are both high. While the master holds the slave selected, the user logic must keep offering the word, because `tx_ready` stays low for the whole transaction.
- A receive-request strobe.
- A strobe that loads all three status flags at once.

The three flags are transmit-ready, receive-ready and receive-overrun. They are also brought out as pins so they can serve as interrupt lines.

MISO is split into a data bit `miso` and an output enable `miso_oe`. A tristate pad outside the block combines the two. `DW` must be at least 3.

Top module: `spi_cmd_slave`

## Requirements
- R1: While `rst_n` is low (asynchronous), `rx_data`, the transmit and receive registers and all three flags are cleared and `miso_oe` is low.
- R2: A frame is 8 command bits followed by `DW` data bits. Both the command and the data are sent most significant bit first. Command bit 7 selects the write target: 0 is the receive register, 1 is the status register. Command bit 6 selects the read source: 0 is the transmit register, 1 is the status register. Command bits 5..0 have no effect.
- R3: With `CPHA`=0, MOSI is sampled on the leading SCLK edge and MISO changes on the trailing edge. With `CPHA`=1, MISO changes on the leading edge and MOSI is sampled on the trailing edge. The leading edge is the one that leaves the idle level `CPOL`.
- R4: `miso_oe` is high exactly while `ss_n` is low and reset is released. MISO is 0 during the command bits. When the read source is the transmit register, the data bits carry that register most significant bit first.
- R5: `tx_ready` equals `!busy`. When `tx_valid` and `tx_ready` are both high, the transmit register takes `tx_data` and `trdy` is 1 in the next cycle. A `tx_valid` while busy has no effect.
- R6: A complete frame whose read source is the transmit register clears `trdy` on its last data bit.
- R7: A complete frame whose write target is the receive register stores the `DW` data bits and sets `rrdy` on its last data bit.
- R8: If `rrdy` is already 1 when such a receive write completes, `roe` becomes 1.
- R9: An `rx_req` while not busy copies the receive register to `rx_data` and clears `rrdy` in the next cycle. While busy, `rx_req` has no effect.
- R10: In a status read, data bits 0, 1 and 2 carry `trdy`, `rrdy` and `roe`, and the later bits are 0.
- R11: In a status write, data bits 0, 1 and 2 load `trdy`, `rrdy` and `roe`, and the later bits are ignored. If the same frame also reads the transmit register, `trdy` ends at 0.
- R12: An `st_load` while not busy loads all three flags from the `st_*_in` pins. It takes priority over a `tx_valid` or `rx_req` in the same cycle. While busy it has no effect.
- R13: Raising `ss_n` before the last data bit leaves the receive register and the flags unchanged.
- R14: `busy` is high exactly while `ss_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master (0 when not enabled) |
| miso_oe | output | 1 | Output enable for the MISO pad |
| busy | output | 1 | High while selected |
| tx_valid | input | 1 | Offer of a transmit word |
| tx_ready | output | 1 | Transmit word can be taken |
| tx_data | input | DW | Transmit word |
| rx_req | input | 1 | Receive request strobe |
| rx_data | output | DW | Last requested received word |
| st_load | input | 1 | Status load strobe |
| st_trdy_in | input | 1 | Value loaded into trdy |
| st_rrdy_in | input | 1 | Value loaded into rrdy |
| st_roe_in | input | 1 | Value loaded into roe |
| trdy | output | 1 | Transmit-ready flag |
| rrdy | output | 1 | Receive-ready flag |
| roe | output | 1 | Receive-overrun flag |

## Verification
The embedded properties watch, on every cycle, that the transmit word cannot change while selected, and that each completed frame moves the flags as its command demands: rrdy and roe after a receive write, trdy cleared after a transmit read. They also check the flag effect of each accepted user strobe. Only the scenarios show the serial behaviour: MISO bit order under both clock modes, status bit placement on read and write, that reserved command bits are ignored, that strobes offered while selected are dropped, and that an aborted frame changes nothing. A behavioural reference model, compared with the outputs every cycle, covers both a mode-0 and a mode-3 instance driven by the same master.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int CMD_BITS  = 8;
  localparam int STAT_BITS = 3;

  typedef struct packed {
    logic trdy;
    logic rrdy;
    logic roe;
  } flags_t;

  typedef enum logic { DST_RX = 1'b0, DST_STAT = 1'b1 } dst_e;
  typedef enum logic { SRC_TX = 1'b0, SRC_STAT = 1'b1 } src_e;
endpackage

// File: rtl/spis_edge.sv
module spis_edge #(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic ss_n,
  output logic sample_ev,
  output logic drive_ev
);
  logic sclk_q;
  logic moved, lead, trail;

  // previous sample of the serial clock; idle level after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= CPOL;
    else        sclk_q <= sclk;
  end

  assign moved = (sclk != sclk_q) && !ss_n;
  assign lead  = moved && (sclk != CPOL);
  assign trail = moved && (sclk == CPOL);

  generate
    if (CPHA == 1'b0) begin : g_ph0
      assign sample_ev = lead;
      assign drive_ev  = trail;
    end else begin : g_ph1
      assign sample_ev = trail;
      assign drive_ev  = lead;
    end
  endgenerate
endmodule

// File: rtl/spis_shift.sv
module spis_shift
  import spis_pkg::*;
#(
  parameter int  DW   = 8,
  parameter bit  CPHA = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_n,
  input  logic          mosi,
  input  logic          sample_ev,
  input  logic          drive_ev,
  input  logic [DW-1:0] tx_word,
  input  flags_t        flags,
  output logic          done,
  output dst_e          dst,
  output src_e          src,
  output logic [DW-1:0] word,
  output logic          miso_bit
);
  localparam int NB  = CMD_BITS + DW;
  localparam int LAG = (CPHA == 1'b1) ? 1 : 0;
  localparam int CW  = $clog2(NB + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] drv;
  logic [DW-2:0] sh;
  int            j;

  // sampled-bit counter; cleared while deselected (drops partial frames)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (ss_n)                               cnt <= '0;
    else if (sample_ev && cnt != CW'(NB))        cnt <= cnt + 1'b1;
  end

  // driven-bit counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  drv <= '0;
    else if (ss_n)                               drv <= '0;
    else if (drive_ev && drv != CW'(NB + LAG))   drv <= drv + 1'b1;
  end

  // command field capture: first bit is the write target, second the read source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst <= DST_RX;
      src <= SRC_TX;
    end else if (sample_ev) begin
      if (cnt == CW'(0)) dst <= dst_e'(mosi);
      if (cnt == CW'(1)) src <= src_e'(mosi);
    end
  end

  // incoming shift chain, keeps the newest DW-1 bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh <= '0;
    else if (sample_ev) sh <= {sh[DW-3:0], mosi};
  end

  assign word = {sh, mosi};
  assign done = sample_ev && (cnt == CW'(NB - 1));

  // outgoing bit selection
  always_comb begin
    miso_bit = 1'b0;
    j = int'(drv) - (CMD_BITS + LAG);
    if (drv >= CW'(CMD_BITS + LAG) && drv < CW'(NB + LAG)) begin
      if (src == SRC_TX) begin
        for (int b = 0; b < DW; b++)
          if (j == b) miso_bit = tx_word[DW-1-b];
      end else begin
        if (j == 0) miso_bit = flags.trdy;
        if (j == 1) miso_bit = flags.rrdy;
        if (j == 2) miso_bit = flags.roe;
      end
    end
  end

  AST_CNT_CLEAR_DESEL: assert property (@(posedge clk) disable iff (!rst_n) ss_n |=> (cnt == '0 && drv == '0)); // R13
endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_req,
  input  logic          st_load,
  input  flags_t        st_in,
  input  logic          done,
  input  dst_e          dst,
  input  src_e          src,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] tx_word,
  output logic [DW-1:0] rx_out,
  output flags_t        flags
);
  logic [DW-1:0] tx_q, rx_q, rxo_q;
  flags_t        fl_q;
  logic          idle;

  assign idle = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tx_q <= '0;
    else if (idle && tx_valid) tx_q <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rx_q <= '0;
    else if (done && dst == DST_RX) rx_q <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rxo_q <= '0;
    else if (idle && rx_req) rxo_q <= rx_q;
  end

  // flags: user strobes while idle, frame completion while selected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q <= '0;
    end else if (idle) begin
      if (tx_valid) fl_q.trdy <= 1'b1;
      if (rx_req)   fl_q.rrdy <= 1'b0;
      if (st_load)  fl_q <= st_in;
    end else if (done) begin
      if (dst == DST_RX) begin
        fl_q.rrdy <= 1'b1;
        if (fl_q.rrdy) fl_q.roe <= 1'b1;
      end else begin
        fl_q <= flags_t'{trdy: word[DW-1], rrdy: word[DW-2], roe: word[DW-3]};
      end
      if (src == SRC_TX) fl_q.trdy <= 1'b0;
    end
  end

  assign tx_word = tx_q;
  assign rx_out  = rxo_q;
  assign flags   = fl_q;

  AST_TX_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(tx_q)); // R5
  AST_TRDY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && tx_valid && !st_load) |=> fl_q.trdy); // R5
  AST_TRDY_CLR_READ: assert property (@(posedge clk) disable iff (!rst_n) (done && src == SRC_TX) |=> !fl_q.trdy); // R6
  AST_RRDY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (done && dst == DST_RX) |=> fl_q.rrdy); // R7
  AST_ROE_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) (done && dst == DST_RX && fl_q.rrdy) |=> fl_q.roe); // R8
  AST_RRDY_CLR_REQ: assert property (@(posedge clk) disable iff (!rst_n) (!busy && rx_req && !st_load) |=> !fl_q.rrdy); // R9
  AST_RX_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(rx_q)); // R7
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spis_pkg::*;
#(
  parameter bit CPOL = 1'b0,
  parameter bit CPHA = 1'b0,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          busy,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_req,
  output logic [DW-1:0] rx_data,
  input  logic          st_load,
  input  logic          st_trdy_in,
  input  logic          st_rrdy_in,
  input  logic          st_roe_in,
  output logic          trdy,
  output logic          rrdy,
  output logic          roe
);
  logic          sample_ev, drive_ev, done, miso_bit;
  dst_e          dst;
  src_e          src;
  logic [DW-1:0] word, tx_word;
  flags_t        flags, st_in;

  assign busy     = !ss_n;
  assign tx_ready = ss_n;
  assign miso_oe  = rst_n && !ss_n;
  assign miso     = miso_oe && miso_bit;
  assign st_in    = flags_t'{trdy: st_trdy_in, rrdy: st_rrdy_in, roe: st_roe_in};

  spis_edge #(.CPOL(CPOL), .CPHA(CPHA)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n),
    .sample_ev(sample_ev), .drive_ev(drive_ev)
  );

  spis_shift #(.DW(DW), .CPHA(CPHA)) u_shift (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .mosi(mosi),
    .sample_ev(sample_ev), .drive_ev(drive_ev),
    .tx_word(tx_word), .flags(flags),
    .done(done), .dst(dst), .src(src), .word(word), .miso_bit(miso_bit)
  );

  spis_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_req(rx_req),
    .st_load(st_load), .st_in(st_in),
    .done(done), .dst(dst), .src(src), .word(word),
    .tx_word(tx_word), .rx_out(rx_data), .flags(flags)
  );

  assign trdy = flags.trdy;
  assign rrdy = flags.rrdy;
  assign roe  = flags.roe;

  AST_DONE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R14
endmodule

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
  localparam int DW = 8;
  localparam int NB = 8 + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk0 = 1'b0, sclk3 = 1'b1, ss_n = 1'b1, mosi = 1'b0;
  logic tx_valid = 1'b0, rx_req = 1'b0, st_load = 1'b0;
  logic st_t = 1'b0, st_r = 1'b0, st_o = 1'b0;
  logic [DW-1:0] tx_data = '0;

  logic miso0, oe0, busy0, txr0, trdy0, rrdy0, roe0;
  logic miso1, oe1, busy1, txr1, trdy1, rrdy1, roe1;
  logic [DW-1:0] rxd0, rxd1;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model state
  logic [DW-1:0] m_tx, m_rx, m_rxd;
  logic m_trdy, m_rrdy, m_roe;
  logic fin = 1'b0;
  logic [7:0] fin_cmd = '0;
  logic [DW-1:0] fin_word = '0;

  always #5 clk = ~clk;

  spi_cmd_slave #(.CPOL(1'b0), .CPHA(1'b0), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk0), .ss_n(ss_n), .mosi(mosi),
    .miso(miso0), .miso_oe(oe0), .busy(busy0), .tx_valid(tx_valid), .tx_ready(txr0),
    .tx_data(tx_data), .rx_req(rx_req), .rx_data(rxd0), .st_load(st_load),
    .st_trdy_in(st_t), .st_rrdy_in(st_r), .st_roe_in(st_o),
    .trdy(trdy0), .rrdy(rrdy0), .roe(roe0));

  spi_cmd_slave #(.CPOL(1'b1), .CPHA(1'b1), .DW(DW)) u1 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk3), .ss_n(ss_n), .mosi(mosi),
    .miso(miso1), .miso_oe(oe1), .busy(busy1), .tx_valid(tx_valid), .tx_ready(txr1),
    .tx_data(tx_data), .rx_req(rx_req), .rx_data(rxd1), .st_load(st_load),
    .st_trdy_in(st_t), .st_rrdy_in(st_r), .st_roe_in(st_o),
    .trdy(trdy1), .rrdy(rrdy1), .roe(roe1));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx <= '0; m_rx <= '0; m_rxd <= '0;
      m_trdy <= 1'b0; m_rrdy <= 1'b0; m_roe <= 1'b0;
    end else begin
      if (ss_n) begin
        if (tx_valid) begin m_tx <= tx_data; m_trdy <= 1'b1; end
        if (rx_req) begin m_rxd <= m_rx; m_rrdy <= 1'b0; end
        if (st_load) begin m_trdy <= st_t; m_rrdy <= st_r; m_roe <= st_o; end
      end
      if (fin) begin
        if (!fin_cmd[7]) begin
          m_rx <= fin_word; m_rrdy <= 1'b1;
          if (m_rrdy) m_roe <= 1'b1;
        end else begin
          m_trdy <= fin_word[DW-1]; m_rrdy <= fin_word[DW-2]; m_roe <= fin_word[DW-3];
        end
        if (!fin_cmd[6]) m_trdy <= 1'b0;
      end
    end
  end

  // per-cycle comparison, one time unit after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R6", "trdy u0", trdy0, m_trdy);   chk("R6", "trdy u1", trdy1, m_trdy);
      chk("R7", "rrdy u0", rrdy0, m_rrdy);   chk("R7", "rrdy u1", rrdy1, m_rrdy);
      chk("R8", "roe u0", roe0, m_roe);      chk("R8", "roe u1", roe1, m_roe);
      chk("R9", "rx_data u0", rxd0, m_rxd);  chk("R9", "rx_data u1", rxd1, m_rxd);
      chk("R14", "busy", busy0, !ss_n);      chk("R14", "busy u1", busy1, !ss_n);
      chk("R5", "tx_ready", txr0, ss_n);     chk("R5", "tx_ready u1", txr1, ss_n);
      chk("R4", "miso_oe", oe0, !ss_n);      chk("R4", "miso_oe u1", oe1, !ss_n);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R14 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master frame; nbits below NB aborts early
  task automatic xfer(input logic [7:0] cmd, input logic [DW-1:0] dat, input int nbits, input string req);
    logic [NB-1:0] frame;
    logic [DW-1:0] exp_rd;
    logic eb;
    frame = {cmd, dat};
    exp_rd = cmd[6] ? {m_trdy, m_rrdy, m_roe, {(DW-3){1'b0}}} : m_tx;
    @(negedge clk);
    ss_n = 1'b0; mosi = frame[NB-1];
    gap(3);
    for (int k = 0; k < nbits; k++) begin
      sclk3 = 1'b0; mosi = frame[NB-1-k];
      gap(3);
      eb = (k < 8) ? 1'b0 : exp_rd[DW-1-(k-8)];
      chk(req, $sformatf("miso mode0 bit %0d", k), miso0, eb);
      chk(req, $sformatf("miso mode3 bit %0d", k), miso1, eb);
      sclk0 = 1'b1; sclk3 = 1'b1;
      if (k == NB-1) begin fin = 1'b1; fin_cmd = cmd; fin_word = dat; end
      gap(1);
      fin = 1'b0;
      gap(2);
      sclk0 = 1'b0;
      gap(3);
    end
    ss_n = 1'b1;
    gap(3);
  endtask

  task automatic strobe(input bit tv, input logic [DW-1:0] td, input bit rq, input bit sl,
                        input bit t, input bit r, input bit o);
    @(negedge clk);
    tx_valid = tv; tx_data = td; rx_req = rq; st_load = sl; st_t = t; st_r = r; st_o = o;
    @(negedge clk);
    tx_valid = 1'b0; rx_req = 1'b0; st_load = 1'b0;
    gap(1);
  endtask

  initial begin
    logic [DW-1:0] keep;
    gap(4);
    chk("R1", "miso_oe in reset", oe0, 0);
    chk("R1", "rx_data in reset", rxd0, 0);
    chk("R1", "flags in reset", {trdy0, rrdy0, roe0}, 0);
    rst_n = 1'b1;
    gap(3);
    chk("R1", "rx_data after reset", rxd1, 0);
    // tx register cleared by reset: read back zero (R1)
    xfer(8'h00, 8'h11, NB, "R1");
    chk("R7", "rrdy after receive write", rrdy0, 1);
    strobe(0, '0, 1, 0, 0, 0, 0);
    chk("R9", "rx_data after request", rxd0, 8'h11);
    chk("R9", "rrdy cleared by request", rrdy0, 0);

    strobe(1, 8'hA5, 0, 0, 0, 0, 0);
    chk("R5", "trdy after load", trdy0, 1);
    xfer(8'h00, 8'h3C, NB, "R4");
    chk("R6", "trdy after transmit read", trdy0, 0);
    // reserved command bits set, second unread write overruns
    xfer(8'h3F, 8'hC3, NB, "R2");
    chk("R8", "roe after overrun", roe0, 1);
    strobe(0, '0, 1, 0, 0, 0, 0);
    chk("R2", "latest word kept", rxd0, 8'hC3);

    strobe(1, 8'h81, 0, 0, 0, 0, 0);
    // status read plus status write: reads 1,0,1 writes 0,1,1
    xfer(8'hC0, 8'h7F, NB, "R10");
    chk("R11", "status write flags", {trdy0, rrdy0, roe0}, 3'b011);
    chk("R3", "mode3 status write flags", {trdy1, rrdy1, roe1}, 3'b011);
    xfer(8'hC0, 8'h1F, NB, "R10");
    chk("R11", "status cleared by master", {trdy0, rrdy0, roe0}, 3'b000);
    // status write of 1,1,1 while reading transmit: trdy ends 0
    xfer(8'h80, 8'hE0, NB, "R4");
    chk("R11", "transmit read beats written trdy", {trdy0, rrdy0, roe0}, 3'b011);
    chk("R11", "receive register untouched", rxd0, 8'hC3);

    // strobes while selected are ignored
    strobe(0, '0, 1, 0, 0, 0, 0);
    keep = rxd0;
    @(negedge clk); ss_n = 1'b0;
    gap(2);
    chk("R5", "tx_ready low while busy", txr0, 0);
    tx_valid = 1'b1; tx_data = 8'hEE; rx_req = 1'b1; st_load = 1'b1; st_t = 1'b1; st_r = 1'b1; st_o = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0; rx_req = 1'b0; st_load = 1'b0;
    gap(2); ss_n = 1'b1; gap(2);
    chk("R12", "status load ignored while busy", {trdy0, rrdy0, roe0}, {m_trdy, m_rrdy, m_roe});
    chk("R9", "request ignored while busy", rxd0, keep);
    xfer(8'h40, 8'h00, NB, "R10");
    strobe(0, '0, 0, 1, 0, 0, 0);
    xfer(8'h00, 8'h5A, NB, "R5");

    // aborted frames
    strobe(0, '0, 1, 1, 0, 0, 0);
    keep = rxd0;
    xfer(8'h00, 8'hF0, 5, "R13");
    xfer(8'h00, 8'hF0, NB-1, "R13");
    chk("R13", "flags after abort", {trdy0, rrdy0, roe0}, 3'b000);
    strobe(0, '0, 1, 0, 0, 0, 0);
    chk("R13", "receive register after abort", rxd0, 8'h5A);

    // status load wins over a same-cycle request and transmit load
    xfer(8'h00, 8'h96, NB, "R7");
    strobe(1, 8'h3E, 1, 1, 0, 1, 1);
    chk("R12", "load wins", {trdy0, rrdy0, roe0}, 3'b011);
    chk("R12", "request still copies data", rxd0, 8'h96);
    xfer(8'h40, 8'h00, NB, "R10");
    xfer(8'h00, 8'h00, NB, "R4");
    chk("R3", "mode3 rx_data track", rxd1, rxd0);

    gap(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule